// File: doc/BRIEF.md
# Streaming Output Test Monitor

This block sits at the far end of a device under test and judges the sample stream that device produces. Software programs a run length, counted in iterations, and a count of leading samples to leave out of the comparison. It then writes the start bit. The monitor raises its ready output and counts the cycles until the first valid sample arrives. From then on it compares every sample with a periodic reference held in an internal table.

Over the whole run it keeps several results: a 64-bit sample count, a count of idle cycles, a count of mismatches and a sticky OR of the error sideband. When the programmed number of iterations has gone by, the monitor drops ready and reports done. An iteration target of zero keeps the run going until software writes stop.

All control and results sit behind a small word-addressed register port. Reads are combinational, and writes take effect at the clock edge.

Top module: `stream_test_monitor`

## Requirements
- R1: After reset, `mon_rdy` is low and every register address from 0 to 9 reads zero.
- R2: Address 1 (iteration target) and address 2 (skip count) read back what was written to them. Writes to addresses 3 to 9 leave the value read there unchanged.
- R3: Address 0 is the control word. Writing it with bit 0 set and bit 1 clear clears every counter, the flag byte and done, and `mon_rdy` is high at the next edge. Bit 1 set with bit 0 clear is stop. A write with both bits set has no effect. Reading address 0 returns running in bit 0, done in bit 1 and first-valid-seen in bit 2.
- R4: Address 7 holds the latency: the number of edges at which ready was high and valid was low before the first valid sample was taken. It does not change after that sample.
- R5: Addresses 3 (low word) and 4 (high word) hold a 64-bit count that rises by one for each edge at which ready and valid are both high.
- R6: Address 5 counts the edges after the first valid sample at which ready is high and valid is low.
- R7: The sample numbered k (from 0, counted since start) is compared with word (k mod REF_LEN + 1) * 0x9E3779B1, truncated to 32 bits, unless k is smaller than the skip count. Address 6 counts the samples that differ.
- R8: Every SAMPLES_PER_ITER counted samples raise the completed-iteration count at address 9 by one. When that count reaches a nonzero target, done is set and ready is low at the same edge.
- R9: With a target of zero the run never finishes by itself. A stop write drops ready and leaves done clear.
- R10: Address 8 holds the OR of all `mon_flags` values sampled while the run is active, meaning the first valid sample has been or is being taken. Flags seen before the first valid sample are ignored. A bit stays set until the next start.
- R11: Samples offered while ready is low change no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| mon_rdy | output | 1 | Ready to the device under test; high while running |
| mon_vld | input | 1 | Sample valid from the device under test |
| mon_dat | input | DATA_W | Sample data |
| mon_flags | input | FLAG_W | Error sideband from the device under test |

## Verification
Every result in this block comes from a register, so a sample or write taken at one edge appears on `cfg_rdata` and `mon_rdy` right after that edge. Done and the fall of ready also land at the edge that takes the last sample of the final iteration. The bench model advances at the same edge as the design. It compares ready, and the register the read address currently points at, at the falling edge that follows, so each result is judged in the cycle it becomes due. Targeted reads at scenario ends are made half a cycle before the next edge, which keeps them free of further stream activity.

// File: rtl/stm_pkg.sv
package stm_pkg;

   localparam int unsigned ADDR_W = 4;
   localparam int unsigned REG_W  = 32;

   localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
   localparam logic [ADDR_W-1:0] A_TARGET = 4'd1;
   localparam logic [ADDR_W-1:0] A_SKIP   = 4'd2;
   localparam logic [ADDR_W-1:0] A_OUT_LO = 4'd3;
   localparam logic [ADDR_W-1:0] A_OUT_HI = 4'd4;
   localparam logic [ADDR_W-1:0] A_IDLE   = 4'd5;
   localparam logic [ADDR_W-1:0] A_MISS   = 4'd6;
   localparam logic [ADDR_W-1:0] A_LAT    = 4'd7;
   localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd8;
   localparam logic [ADDR_W-1:0] A_ITERS  = 4'd9;

   localparam int unsigned CTRL_GO   = 0;
   localparam int unsigned CTRL_HALT = 1;

   localparam logic [31:0] REF_MULT = 32'h9E3779B1;

   // expected word at table position k
   function automatic logic [31:0] ref_word(input int unsigned k);
      logic [31:0] t;
      t = k + 32'd1;
      return t * REF_MULT;
   endfunction

endpackage

// File: rtl/stm_ref_seq.sv
module stm_ref_seq #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned REF_LEN = 997
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              adv,
   output logic [DATA_W-1:0] word
);
   localparam int unsigned IDX_W = $clog2(REF_LEN);
   localparam bit          POW2  = (REF_LEN & (REF_LEN - 1)) == 0;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(REF_LEN - 1);

   logic [DATA_W-1:0] table_q [REF_LEN];
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  idx_nxt;

   for (genvar g = 0; g < REF_LEN; g++) begin : g_tab
      assign table_q[g] = DATA_W'(stm_pkg::ref_word(g));
   end

   if (POW2) begin : g_wrap_free
      assign idx_nxt = idx + 1'b1;
   end else begin : g_wrap_cmp
      assign idx_nxt = (idx == IDX_LAST) ? '0 : idx + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   idx <= '0;
      else if (clr) idx <= '0;
      else if (adv) idx <= idx_nxt;
   end

   assign word = table_q[idx];
endmodule

// File: rtl/stm_stream_core.sv
module stm_stream_core #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned FLAG_W = 2,
   parameter int unsigned SPI    = 8192,
   parameter int unsigned ITER_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_p,
   input  logic              stop_p,
   input  logic [ITER_W-1:0] target,
   input  logic [31:0]       skip,
   input  logic              vld,
   input  logic [DATA_W-1:0] dat,
   input  logic [FLAG_W-1:0] flags_in,
   input  logic [DATA_W-1:0] ref_w,
   output logic              ref_adv,
   output logic              running,
   output logic              done,
   output logic              seen,
   output logic [63:0]       out_cnt,
   output logic [31:0]       idle_cnt,
   output logic [31:0]       miss_cnt,
   output logic [31:0]       lat_cnt,
   output logic [7:0]        flag_acc,
   output logic [ITER_W-1:0] iters
);
   localparam int unsigned SII_W = $clog2(SPI);
   localparam logic [SII_W-1:0] SII_LAST = SII_W'(SPI - 1);

   logic [SII_W-1:0]  sii;
   logic              cmp_en;
   logic              last_iter;
   logic [ITER_W-1:0] iters_inc;

   assign cmp_en    = out_cnt >= {32'd0, skip};
   assign iters_inc = iters + 1'b1;
   assign last_iter = (target != '0) && (iters_inc == target);
   assign ref_adv   = running && vld && !start_p && !stop_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running  <= 1'b0;
         done     <= 1'b0;
         seen     <= 1'b0;
         out_cnt  <= '0;
         idle_cnt <= '0;
         miss_cnt <= '0;
         lat_cnt  <= '0;
         flag_acc <= '0;
         iters    <= '0;
         sii      <= '0;
      end else if (start_p) begin
         running  <= 1'b1;
         done     <= 1'b0;
         seen     <= 1'b0;
         out_cnt  <= '0;
         idle_cnt <= '0;
         miss_cnt <= '0;
         lat_cnt  <= '0;
         flag_acc <= '0;
         iters    <= '0;
         sii      <= '0;
      end else if (stop_p) begin
         running <= 1'b0;
      end else if (running) begin
         if (vld) begin
            seen    <= 1'b1;
            out_cnt <= out_cnt + 64'd1;
            if (cmp_en && (dat != ref_w)) miss_cnt <= miss_cnt + 32'd1;
            if (sii == SII_LAST) begin
               sii   <= '0;
               iters <= iters_inc;
               if (last_iter) begin
                  running <= 1'b0;
                  done    <= 1'b1;
               end
            end else begin
               sii <= sii + 1'b1;
            end
         end else if (seen) begin
            idle_cnt <= idle_cnt + 32'd1;
         end else begin
            lat_cnt <= lat_cnt + 32'd1;
         end
         if (seen || vld) flag_acc <= flag_acc | 8'(flags_in);
      end
   end
endmodule

// File: rtl/stm_regfile.sv
module stm_regfile #(
   parameter int unsigned ITER_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [3:0]        addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              start_p,
   output logic              stop_p,
   output logic [ITER_W-1:0] target,
   output logic [31:0]       skip,
   input  logic              running,
   input  logic              done,
   input  logic              seen,
   input  logic [63:0]       out_cnt,
   input  logic [31:0]       idle_cnt,
   input  logic [31:0]       miss_cnt,
   input  logic [31:0]       lat_cnt,
   input  logic [7:0]        flag_acc,
   input  logic [ITER_W-1:0] iters
);
   import stm_pkg::*;

   logic ctrl_wr;
   assign ctrl_wr = wr_en && (addr == A_CTRL);
   assign start_p = ctrl_wr && wdata[CTRL_GO] && !wdata[CTRL_HALT];
   assign stop_p  = ctrl_wr && wdata[CTRL_HALT] && !wdata[CTRL_GO];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         target <= '0;
         skip   <= '0;
      end else if (wr_en) begin
         if (addr == A_TARGET) target <= wdata[ITER_W-1:0];
         if (addr == A_SKIP)   skip   <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_CTRL:   rdata = {29'd0, seen, done, running};
         A_TARGET: rdata = 32'(target);
         A_SKIP:   rdata = skip;
         A_OUT_LO: rdata = out_cnt[31:0];
         A_OUT_HI: rdata = out_cnt[63:32];
         A_IDLE:   rdata = idle_cnt;
         A_MISS:   rdata = miss_cnt;
         A_LAT:    rdata = lat_cnt;
         A_FLAGS:  rdata = 32'(flag_acc);
         A_ITERS:  rdata = 32'(iters);
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/stream_test_monitor.sv
module stream_test_monitor #(
   parameter int unsigned DATA_W           = 32,
   parameter int unsigned FLAG_W           = 2,
   parameter int unsigned REF_LEN          = 997,
   parameter int unsigned SAMPLES_PER_ITER = 8192,
   parameter int unsigned ITER_W           = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [3:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic              mon_rdy,
   input  logic              mon_vld,
   input  logic [DATA_W-1:0] mon_dat,
   input  logic [FLAG_W-1:0] mon_flags
);
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_data
      $error("DATA_W must lie in 1..32");
   end
   if (FLAG_W < 1 || FLAG_W > 8) begin : g_bad_flag
      $error("FLAG_W must lie in 1..8");
   end
   if (REF_LEN < 2 || REF_LEN > 4096) begin : g_bad_ref
      $error("REF_LEN must lie in 2..4096");
   end
   if (SAMPLES_PER_ITER < 2) begin : g_bad_spi
      $error("SAMPLES_PER_ITER must be at least 2");
   end
   if (ITER_W < 1 || ITER_W > 32) begin : g_bad_iter
      $error("ITER_W must lie in 1..32");
   end

   logic              start_p, stop_p;
   logic [ITER_W-1:0] target;
   logic [31:0]       skip;
   logic [DATA_W-1:0] ref_w;
   logic              ref_adv;
   logic              running, done, seen;
   logic [63:0]       out_cnt;
   logic [31:0]       idle_cnt, miss_cnt, lat_cnt;
   logic [7:0]        flag_acc;
   logic [ITER_W-1:0] iters;

   stm_regfile #(.ITER_W(ITER_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_wr_en), .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
      .start_p(start_p), .stop_p(stop_p), .target(target), .skip(skip),
      .running(running), .done(done), .seen(seen), .out_cnt(out_cnt),
      .idle_cnt(idle_cnt), .miss_cnt(miss_cnt), .lat_cnt(lat_cnt),
      .flag_acc(flag_acc), .iters(iters)
   );

   stm_ref_seq #(.DATA_W(DATA_W), .REF_LEN(REF_LEN)) u_ref (
      .clk(clk), .rst_n(rst_n), .clr(start_p), .adv(ref_adv), .word(ref_w)
   );

   stm_stream_core #(
      .DATA_W(DATA_W), .FLAG_W(FLAG_W), .SPI(SAMPLES_PER_ITER), .ITER_W(ITER_W)
   ) u_core (
      .clk(clk), .rst_n(rst_n), .start_p(start_p), .stop_p(stop_p),
      .target(target), .skip(skip), .vld(mon_vld), .dat(mon_dat),
      .flags_in(mon_flags), .ref_w(ref_w), .ref_adv(ref_adv),
      .running(running), .done(done), .seen(seen), .out_cnt(out_cnt),
      .idle_cnt(idle_cnt), .miss_cnt(miss_cnt), .lat_cnt(lat_cnt),
      .flag_acc(flag_acc), .iters(iters)
   );

   assign mon_rdy = running;
endmodule

// File: rtl/stm_checker.sv
module stm_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic        rdy,
   input logic        vld,
   input logic        seen,
   input logic        done,
   input logic [63:0] out_cnt,
   input logic [31:0] idle_cnt,
   input logic [31:0] lat_cnt,
   input logic [7:0]  flag_acc
);
   a_r8_done_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> !rdy);

   a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && vld && !wr_en) |=> (out_cnt == $past(out_cnt) + 64'd1));

   a_r6_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && seen && !vld && !wr_en) |=> (idle_cnt == $past(idle_cnt) + 32'd1));

   a_r4_latency_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !wr_en) |=> $stable(lat_cnt));

   a_r10_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ((flag_acc & $past(flag_acc)) == $past(flag_acc)));

   a_r11_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy && !wr_en) |=> $stable(out_cnt));
endmodule

bind stream_test_monitor stm_checker u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .rdy(mon_rdy), .vld(mon_vld),
   .seen(seen), .done(done), .out_cnt(out_cnt), .idle_cnt(idle_cnt),
   .lat_cnt(lat_cnt), .flag_acc(flag_acc)
);

// File: tb/stream_test_monitor_tb_top.sv
module stream_test_monitor_tb_top;
   localparam int unsigned REF = 7;
   localparam int unsigned SPI = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wd = '0;
   logic [31:0] rd;
   logic        rdy;
   logic        vld = 1'b0;
   logic [31:0] dat = '0;
   logic [1:0]  flg = '0;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   stream_test_monitor #(
      .DATA_W(32), .FLAG_W(2), .REF_LEN(REF), .SAMPLES_PER_ITER(SPI), .ITER_W(32)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr), .cfg_addr(addr), .cfg_wdata(wd),
      .cfg_rdata(rd), .mon_rdy(rdy), .mon_vld(vld), .mon_dat(dat), .mon_flags(flg)
   );

   // behavioural reference model
   bit          m_run, m_done, m_seen;
   logic [63:0] m_out;
   logic [31:0] m_idle, m_mis, m_lat, m_tgt, m_skip, m_it;
   logic [7:0]  m_flg;
   int          m_sii;

   function automatic logic [31:0] ref_w(logic [63:0] k);
      logic [31:0] i;
      i = 32'(k % REF) + 32'd1;
      return i * 32'h9E3779B1;
   endfunction

   function automatic logic [31:0] mreg(logic [3:0] a);
      case (a)
         4'd0: return {29'd0, m_seen, m_done, m_run};
         4'd1: return m_tgt;
         4'd2: return m_skip;
         4'd3: return m_out[31:0];
         4'd4: return m_out[63:32];
         4'd5: return m_idle;
         4'd6: return m_mis;
         4'd7: return m_lat;
         4'd8: return {24'd0, m_flg};
         4'd9: return m_it;
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(logic [3:0] a);
      case (a)
         4'd0: return "R3";
         4'd1, 4'd2: return "R2";
         4'd3, 4'd4: return "R5";
         4'd5: return "R6";
         4'd6: return "R7";
         4'd7: return "R4";
         4'd8: return "R10";
         4'd9: return "R8";
         default: return "R1";
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_done = 0; m_seen = 0; m_out = 0; m_idle = 0; m_mis = 0;
         m_lat = 0; m_tgt = 0; m_skip = 0; m_it = 0; m_flg = 0; m_sii = 0;
      end else begin
         bit st, sp;
         st = wr && addr == 4'd0 && wd[0] && !wd[1];
         sp = wr && addr == 4'd0 && wd[1] && !wd[0];
         if (wr && addr == 4'd1) m_tgt = wd;
         if (wr && addr == 4'd2) m_skip = wd;
         if (st) begin
            m_run = 1; m_done = 0; m_seen = 0; m_out = 0; m_idle = 0; m_mis = 0;
            m_lat = 0; m_it = 0; m_flg = 0; m_sii = 0;
         end else if (sp) begin
            m_run = 0;
         end else if (m_run) begin
            if (m_seen || vld) m_flg = m_flg | {6'd0, flg};
            if (vld) begin
               if (m_out >= {32'd0, m_skip} && dat != ref_w(m_out)) m_mis++;
               m_out++;
               m_seen = 1;
               m_sii++;
               if (m_sii == SPI) begin
                  m_sii = 0;
                  m_it++;
                  if (m_tgt != 0 && m_it == m_tgt) begin
                     m_run = 0; m_done = 1;
                  end
               end
            end else if (m_seen) m_idle++;
            else m_lat++;
         end
      end
   end

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      cyc++;
      chk("R3 ready", {63'd0, rdy}, {63'd0, m_run});
      chk(tag_of(addr), {32'd0, rd}, {32'd0, mreg(addr)});
   endtask

   task automatic rdx(logic [3:0] a, logic [31:0] exp, string tag);
      addr = a;
      #1;
      chk(tag, {32'd0, rd}, {32'd0, exp});
   endtask

   task automatic wreg(logic [3:0] a, logic [31:0] d);
      wr = 1'b1; addr = a; wd = d; vld = 1'b0; flg = '0;
      tick();
      wr = 1'b0;
   endtask

   task automatic send(int k, bit bad, logic [1:0] f);
      addr = 4'(cyc % 10);
      vld = 1'b1;
      dat = bad ? ~ref_w(64'(k)) : ref_w(64'(k));
      flg = f;
      tick();
   endtask

   task automatic gap(logic [1:0] f);
      addr = 4'(cyc % 10);
      vld = 1'b0;
      flg = f;
      tick();
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 ready", {63'd0, rdy}, 64'd0);
      for (int a = 0; a < 10; a++) rdx(4'(a), 32'd0, "R1");

      // run A: 3 iterations, skip 2 garbage samples, latency 5
      wreg(4'd1, 32'd3);
      wreg(4'd2, 32'd2);
      rdx(4'd1, 32'd3, "R2");
      rdx(4'd2, 32'd2, "R2");
      wreg(4'd0, 32'd1);
      chk("R3 ready up", {63'd0, rdy}, 64'd1);
      repeat (5) gap(2'b00);
      for (int k = 0; k < 48; k++) send(k, k < 2, 2'b00);
      chk("R8 ready low at done", {63'd0, rdy}, 64'd0);
      for (int k = 0; k < 3; k++) send(48 + k, 1'b0, 2'b00); // R11 ignored
      vld = 1'b0;
      rdx(4'd7, 32'd5, "R4");
      rdx(4'd3, 32'd48, "R11");
      rdx(4'd4, 32'd0, "R5");
      rdx(4'd9, 32'd3, "R8");
      rdx(4'd0, 32'd6, "R8");
      rdx(4'd6, 32'd0, "R7");
      rdx(4'd5, 32'd0, "R6");

      // run B: 2 iterations, idle gaps, corruption, flags
      wreg(4'd1, 32'd2);
      wreg(4'd2, 32'd0);
      wreg(4'd0, 32'd1);
      repeat (3) gap(2'b01);                // R10 flags before first valid ignored
      for (int k = 0; k < 32; k++) begin
         if (k % 7 == 6) gap(2'b00);
         send(k, (k == 10) || (k == 25), (k == 15) ? 2'b10 : 2'b00);
      end
      vld = 1'b0;
      rdx(4'd7, 32'd3, "R4");
      rdx(4'd5, 32'd4, "R6");
      rdx(4'd6, 32'd2, "R7");
      rdx(4'd8, 32'h2, "R10");
      rdx(4'd3, 32'd32, "R5");
      rdx(4'd9, 32'd2, "R8");

      // run C: free running, stopped by software
      wreg(4'd1, 32'd0);
      wreg(4'd0, 32'd1);
      for (int k = 0; k < 40; k++) send(k, 1'b0, 2'b00);
      gap(2'b00);
      gap(2'b00);
      chk("R9 still running", {63'd0, rdy}, 64'd1);
      wreg(4'd0, 32'd2);
      chk("R9 ready after stop", {63'd0, rdy}, 64'd0);
      rdx(4'd0, 32'd4, "R9");
      rdx(4'd9, 32'd2, "R9");
      rdx(4'd3, 32'd40, "R5");
      rdx(4'd7, 32'd0, "R4");
      rdx(4'd5, 32'd2, "R6");

      // both control bits set: ignored
      wreg(4'd0, 32'd3);
      chk("R3 both bits", {63'd0, rdy}, 64'd0);
      rdx(4'd3, 32'd40, "R3");
      // writes to result registers ignored
      wreg(4'd3, 32'd0);
      wreg(4'd5, 32'hFFFF);
      rdx(4'd3, 32'd40, "R2");
      rdx(4'd5, 32'd2, "R2");

      // restart clears everything
      wreg(4'd0, 32'd1);
      rdx(4'd3, 32'd0, "R3");
      rdx(4'd0, 32'd1, "R3");
      rdx(4'd9, 32'd0, "R3");
      wreg(4'd0, 32'd2);
      rdx(4'd0, 32'd0, "R9");

      finish_run();
   end
endmodule